// File: doc/BRIEF.md
# Deferred DRAM Refresh Scheduler

This block sits beside a DRAM command sequencer and decides when auto-refresh commands go out. Each periodic refresh tick adds one to a backlog instead of forcing an immediate refresh. The backlog is drained opportunistically. When the read and write command queues have both been empty for a programmable number of cycles, the block requests refreshes one after another. It checks the queues again before each further request. If traffic never lets up and the backlog reaches a programmable threshold, the block raises a single urgent request to bring the backlog back under the limit. It then returns to waiting for an idle window.

When self-refresh is enabled, opportunistic draining waits until the controller reports that it has actually entered self-refresh. Each request is held until the sequencer acknowledges it, and each acknowledge retires one refresh from the backlog.

Top module: `ref_postpone_sched`

## Requirements
- R1: After reset, `ref_req_o` and `ref_urgent_o` are low and `pend_o` is 0.
- R2: A `tick_i` pulse without a simultaneous accepted acknowledge raises `pend_o` by one on the next clock edge, up to MAX_PEND (8).
- R3: With `sr_en_i` low and at least one refresh pending, `ref_req_o` rises exactly `idle_cycles_i`+1 cycles after both `rd_empty_i` and `wr_empty_i` are first seen high, and `ref_urgent_o` stays low.
- R4: The idle count restarts from zero whenever either queue is non-empty for a cycle, so a broken idle window delays the request by a full idle period.
- R5: In an idle window, every pending refresh is requested in turn, one per acknowledge, until `pend_o` is 0.
- R6: If either queue becomes non-empty during a batch, no further request is raised after the current one is acknowledged, and the remaining backlog is kept.
- R7: When `pend_o` reaches the effective threshold, `ref_req_o` and `ref_urgent_o` rise on the next edge even while the queues are busy. After that one refresh is acknowledged, no further request is raised while the queues stay busy. A `thresh_i` of 0 or above 8 acts as 8.
- R8: `ref_req_o` stays high until `ref_ack_i` is seen with it, and an accepted acknowledge lowers `pend_o` by one.
- R9: `ref_ack_i` while `ref_req_o` is low has no effect on `pend_o` or on the requests.
- R10: With `sr_en_i` high, no non-urgent request is raised while `sr_active_i` is low, even with idle queues. Once `sr_active_i` goes high, the whole backlog is requested.
- R11: A tick that arrives while `pend_o` is 8 and no acknowledge is accepted is held as one owed refresh. The next accepted acknowledge leaves `pend_o` at 8, and the request that follows is urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Periodic refresh due pulse |
| rd_empty_i | input | 1 | Read command queue empty |
| wr_empty_i | input | 1 | Write command queue empty |
| sr_en_i | input | 1 | Self-refresh enabled; defer opportunistic refresh |
| sr_active_i | input | 1 | Controller is in self-refresh |
| thresh_i | input | CNT_W (4) | Backlog level that forces an urgent refresh |
| idle_cycles_i | input | IDLE_W (8) | Idle cycles required before draining |
| ref_ack_i | input | 1 | Sequencer accepted the refresh request |
| ref_req_o | output | 1 | Refresh request to sequencer |
| ref_urgent_o | output | 1 | Current request was forced by the backlog |
| pend_o | output | CNT_W (4) | Refreshes outstanding |

## Verification
A corrupted backlog count appears directly on `pend_o` on the edge after the tick or acknowledge that caused it. It also shifts the urgent point, so a sweep of every threshold from 1 to 8 exposes an off-by-one within one tick. A wrong idle counter moves the request edge by at least a cycle, which a latency measurement for several idle settings catches at once. A request state machine that fails to hold, or that re-fires on a stray acknowledge, shows as an extra or missing request within a few cycles of the acknowledge.

// File: rtl/refpp_pkg.sv
package refpp_pkg;
  typedef enum logic {ISS_WAIT = 1'b0, ISS_REQ = 1'b1} iss_state_e;
endpackage

// File: rtl/refpp_idle_timer.sv
module refpp_idle_timer #(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  logic [IDLE_W-1:0] limit_i,
  output logic              ready_o
);
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!empty_i)        cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  // counts prior empty cycles; current cycle must also be empty
  assign ready_o = empty_i && (cnt_q >= limit_i);
endmodule

// File: rtl/refpp_pend_ctr.sv
module refpp_pend_ctr #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             owe_o
);
  localparam logic [CNT_W:0] MaxV = (CNT_W+1)'(MAX_PEND);

  logic [CNT_W-1:0] cnt_q;
  logic             owe_q;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick_i} + {{CNT_W{1'b0}}, owe_q}
        - {{CNT_W{1'b0}}, dec_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      owe_q <= 1'b0;
    end else if (sum > MaxV) begin
      cnt_q <= MaxV[CNT_W-1:0];
      owe_q <= 1'b1;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
      owe_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign owe_o = owe_q;
endmodule

// File: rtl/ref_postpone_sched.sv
module ref_postpone_sched
  import refpp_pkg::*;
#(
  parameter int MAX_PEND = 8,
  parameter int IDLE_W   = 8,
  localparam int CNT_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_empty_i,
  input  logic              wr_empty_i,
  input  logic              sr_en_i,
  input  logic              sr_active_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [IDLE_W-1:0] idle_cycles_i,
  input  logic              ref_ack_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o,
  output logic [CNT_W-1:0]  pend_o
);
  localparam logic [CNT_W-1:0] MaxC = CNT_W'(MAX_PEND);

  iss_state_e       state_q;
  logic             urg_q;
  logic             idle_ready;
  logic             ack_ok;
  logic [CNT_W-1:0] cnt;
  logic             owe;
  logic [CNT_W-1:0] eff_thr;
  logic             urgent_c;
  logic             opp_c;

  assign ack_ok = (state_q == ISS_REQ) && ref_ack_i;

  refpp_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (rd_empty_i && wr_empty_i),
    .limit_i (idle_cycles_i),
    .ready_o (idle_ready)
  );

  refpp_pend_ctr #(.MAX_PEND(MAX_PEND), .CNT_W(CNT_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .dec_i  (ack_ok),
    .cnt_o  (cnt),
    .owe_o  (owe)
  );

  always_comb begin
    eff_thr  = (thresh_i == '0 || thresh_i > MaxC) ? MaxC : thresh_i;
    urgent_c = owe || (cnt >= eff_thr);
    opp_c    = (cnt != '0) && (sr_en_i ? sr_active_i : idle_ready);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ISS_WAIT;
      urg_q   <= 1'b0;
    end else begin
      case (state_q)
        ISS_WAIT: if (urgent_c || opp_c) begin
          state_q <= ISS_REQ;
          urg_q   <= urgent_c;
        end
        default: if (ref_ack_i) begin
          state_q <= ISS_WAIT;
          urg_q   <= 1'b0;
        end
      endcase
    end
  end

  assign ref_req_o    = (state_q == ISS_REQ);
  assign ref_urgent_o = urg_q;
  assign pend_o       = cnt;
endmodule

// File: rtl/ref_postpone_sched_chk.sv
module ref_postpone_sched_chk #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             rd_empty_i,
  input logic             wr_empty_i,
  input logic             sr_en_i,
  input logic             sr_active_i,
  input logic             ref_ack_i,
  input logic             ref_req_o,
  input logic             ref_urgent_o,
  input logic [CNT_W-1:0] pend_o
);
  assert_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o <= CNT_W'(MAX_PEND));

  assert_tick_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(ref_req_o && ref_ack_i) && pend_o < CNT_W'(MAX_PEND))
    |=> pend_o == $past(pend_o) + 1'b1);

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);

  assert_ack_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_ack_i && !tick_i) |=> pend_o <= $past(pend_o));

  assert_no_empty_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_req_o && pend_o == '0) |=> !ref_req_o);

  assert_urgent_with_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o);

  assert_sr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_req_o && sr_en_i && !sr_active_i) |=> (!ref_req_o || ref_urgent_o));

  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_req_o && !sr_en_i && !(rd_empty_i && wr_empty_i)) |=> (!ref_req_o || ref_urgent_o));
endmodule

bind ref_postpone_sched ref_postpone_sched_chk #(.MAX_PEND(MAX_PEND), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .rd_empty_i   (rd_empty_i),
  .wr_empty_i   (wr_empty_i),
  .sr_en_i      (sr_en_i),
  .sr_active_i  (sr_active_i),
  .ref_ack_i    (ref_ack_i),
  .ref_req_o    (ref_req_o),
  .ref_urgent_o (ref_urgent_o),
  .pend_o       (pend_o)
);

// File: tb/tb_ref_postpone_sched.sv
`timescale 1ns/1ps
module tb_ref_postpone_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd_e = 1'b0, wr_e = 1'b0, sr_en = 1'b0, sr_act = 1'b0, ack = 1'b0;
  logic [3:0] thr = 4'd8;
  logic [7:0] idle_n = 8'd0;
  logic       req, urg;
  logic [3:0] pend;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ref_postpone_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_empty_i(rd_e), .wr_empty_i(wr_e),
    .sr_en_i(sr_en), .sr_active_i(sr_act), .thresh_i(thr), .idle_cycles_i(idle_n),
    .ref_ack_i(ack), .ref_req_o(req), .ref_urgent_o(urg), .pend_o(pend)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic busy(); rd_e = 1'b0; wr_e = 1'b0; endtask

  // wait for req then acknowledge once; returns urgent flag seen
  task automatic do_ack(output logic u);
    int w = 0;
    while (!req && w < 100) begin @(negedge clk); w++; end
    u = urg;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic drain();
    logic u;
    int g = 0;
    sr_en = 1'b0; rd_e = 1'b1; wr_e = 1'b1;
    while (pend != 0 && g < 20) begin do_ack(u); g++; end
    busy(); cyc(2);
  endtask

  task automatic latency(input int n, input string rq);
    int k = 0;
    logic u;
    idle_n = 8'(n); thr = 4'd8;
    pulse_tick(); cyc(1);
    rd_e = 1'b1; wr_e = 1'b1;
    while (!req && k < 50) begin @(negedge clk); k++; end
    chk(rq, k, n + 1);
    chk(rq, urg, 0);
    do_ack(u); busy(); cyc(2);
    chk(rq, pend, 0);
  endtask

  initial begin
    #(8ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic u;
    int n;
    cyc(3);
    chk("R1 req", req, 0); chk("R1 urg", urg, 0); chk("R1 pend", pend, 0);
    rst_n = 1'b1; cyc(2);

    // R2 / R7: threshold sweep with busy queues
    for (int t = 1; t <= 8; t++) begin
      thr = 4'(t);
      for (int i = 1; i <= t; i++) begin
        pulse_tick();
        chk("R2 pend", pend, i);
        cyc(1);
        chk("R7 req", req, (i >= t) ? 1 : 0);
      end
      chk("R7 urg", urg, 1);
      do_ack(u);
      cyc(4);
      chk("R8 pend after ack", pend, t - 1);
      chk("R7 single", req, 0);
      drain();
    end

    // R7: thresh 0 acts as 8
    thr = 4'd0;
    for (int i = 0; i < 7; i++) pulse_tick();
    cyc(2); chk("R7 thr0 below", req, 0);
    pulse_tick(); cyc(1); chk("R7 thr0 at 8", urg, 1);
    // R11: tick at saturation is owed
    pulse_tick(); chk("R11 sat", pend, 8);
    do_ack(u); chk("R11 owed", pend, 8);
    cyc(1); chk("R11 urgent again", urg, 1);
    do_ack(u); chk("R11 after", pend, 7);
    cyc(3); chk("R11 no more", req, 0);
    drain();

    // R3: idle latency sweep
    for (int n2 = 0; n2 < 6; n2++) latency(n2, "R3 latency");

    // R4: broken idle window
    idle_n = 8'd5; thr = 4'd8;
    pulse_tick();
    rd_e = 1'b1; wr_e = 1'b1; cyc(3);
    rd_e = 1'b0; cyc(1);
    rd_e = 1'b1;
    n = 0;
    while (!req && n < 50) begin @(negedge clk); n++; end
    chk("R4 restart", n, 6);
    drain();

    // R5: full batch
    idle_n = 8'd2; thr = 4'd8;
    for (int i = 0; i < 5; i++) pulse_tick();
    rd_e = 1'b1; wr_e = 1'b1;
    n = 0;
    while (pend != 0 && n < 20) begin do_ack(u); n++; chk("R5 non-urgent", u, 0); end
    chk("R5 batch len", n, 5);
    cyc(5); chk("R5 done", req, 0);
    busy(); cyc(2);

    // R6: batch interrupted
    for (int i = 0; i < 5; i++) pulse_tick();
    rd_e = 1'b1; wr_e = 1'b1;
    do_ack(u);
    n = 0; while (!req && n < 50) begin @(negedge clk); n++; end
    ack = 1'b1; @(negedge clk); ack = 1'b0; rd_e = 1'b0;
    cyc(10);
    chk("R6 stop", req, 0); chk("R6 kept", pend, 3);
    drain();

    // R9: stray ack
    pulse_tick(); pulse_tick(); cyc(1);
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(2);
    chk("R9 pend", pend, 2); chk("R9 req", req, 0);
    drain();

    // R10: self-refresh hold
    sr_en = 1'b1; rd_e = 1'b1; wr_e = 1'b1; idle_n = 8'd0;
    for (int i = 0; i < 3; i++) pulse_tick();
    cyc(20);
    chk("R10 hold", req, 0); chk("R10 pend", pend, 3);
    sr_act = 1'b1;
    n = 0;
    while (pend != 0 && n < 20) begin do_ack(u); n++; end
    chk("R10 drained", n, 3);
    sr_act = 1'b0; sr_en = 1'b0; busy(); cyc(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule